// File: doc/BRIEF.md
# Extended RAM Access Decoder

This block sits beside an 8051-style core and settles, for every transfer to external data memory, whether a small on-chip RAM or the external bus answers it. The core presents the transfer together with its kind. A wide-pointer transfer carries a full 16-bit address, and its high byte is compared against a programmable window register. A paged transfer carries only an 8-bit low address, and the high byte comes from a page register. When the high byte matches the window and the on-chip RAM is enabled, the block serves the access from its own 256-byte array. In every other case it leaves the access to the external bus.

Two mapping control bits govern the on-chip RAM. The low bit is a disable bit: it comes out of reset set, software may clear it, and only a reset can set it again. The high bit keeps the external read and write strobe enables active during on-chip accesses. The page register shadows port-2 writes, so paged software written for an external page latch still reaches the right page. The RAM array has no reset, and its contents survive any number of resets.

Top module: `xram_decoder`

## Requirements
- R1: After reset the window register reads F8h, the mapping bits read binary 01, the page register reads 00h, and the read-hit flag is 0.
- R2: While mapping bit 0 is 1, no access selects the on-chip RAM, and reads and writes drive the external strobe enables whatever the high byte is.
- R3: A mapping write sets bit 1 to the written value and bit 0 to (old bit 0 AND written bit 0). Once bit 0 is 0, it returns to 1 only through reset.
- R4: A wide-pointer access (paged = 0) with bit 0 clear selects the on-chip RAM exactly when the pointer high byte equals the window register.
- R5: A paged access (paged = 1) with bit 0 clear selects the on-chip RAM exactly when the page register equals the window register. The pointer high byte has no effect on this decision.
- R6: On an on-chip access with mapping bit 1 clear, both external strobe enables stay low. With bit 1 set, the enable for the access direction is driven high.
- R7: A port-2 write copies its byte into the page register. The page register's own write strobe also loads it, and that strobe wins when both strobes fire in the same cycle.
- R8: Reset does not alter the RAM contents.
- R9: Every write access raises the low-bus write-data enable, whether it goes on-chip or external. The bus read-data take signal is high only for reads that go external.
- R10: A read that selects the on-chip RAM raises the read-hit flag and presents the stored byte in the next cycle. External reads and all writes leave the flag low.
- R11: An on-chip write stores its data at the low address byte, raises the RAM write strobe in the access cycle, and does not change other locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A data-memory transfer is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_paged | input | 1 | 1 = 8-bit paged access, 0 = 16-bit pointer access |
| acc_hi | input | 8 | Pointer high byte (used only for pointer accesses) |
| acc_lo | input | 8 | Low address byte |
| acc_wdata | input | 8 | Write data |
| win_we | input | 1 | Window register write strobe |
| win_wdata | input | 8 | Window register write value |
| map_we | input | 1 | Mapping control write strobe |
| map_wdata | input | 2 | Mapping control write value |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write value |
| p2_we | input | 1 | Port-2 latch write strobe (shadowed into page) |
| p2_wdata | input | 8 | Port-2 write value |
| win_q | output | 8 | Window register value |
| map_q | output | 2 | Mapping control value |
| page_q | output | 8 | Page register value |
| xram_sel | output | 1 | Access is served by the on-chip RAM |
| xram_we | output | 1 | On-chip RAM write strobe |
| ext_rd_en | output | 1 | External read strobe enable |
| ext_wr_en | output | 1 | External write strobe enable |
| bus_wdata_en | output | 1 | Drive write data on the low bus |
| bus_rdata_take | output | 1 | Capture read data from the external bus |
| rd_hit | output | 1 | Registered: internal read data valid |
| rdata | output | 8 | Registered on-chip read data |

## Verification
The hardest state to reach is the one-way lock of the disable bit together with retention of the RAM across reset. The stimulus clears the bit, tries to set it again with several write values, fills the whole RAM through the window, and then applies reset in the middle of the run. After reset the window is reopened and all 256 locations are read back. The paged decode is swept over all 256 page values while the pointer high byte is held at the window value, so that any leak from the pointer byte into the paged decision shows up as a false hit.

// File: rtl/xram_pkg.sv
package xram_pkg;

    parameter int HI_W   = 8;
    parameter int LO_W   = 8;
    parameter int DATA_W = 8;
    localparam int DEPTH = 1 << LO_W;

    localparam logic [HI_W-1:0] WIN_RESET  = 8'hF8;
    localparam logic [1:0]      MAP_RESET  = 2'b01;
    localparam logic [HI_W-1:0] PAGE_RESET = '0;

    // mapping bit positions
    localparam int MAP_OFF_BIT  = 0;
    localparam int MAP_SHOW_BIT = 1;

    typedef enum logic { ACC_POINTER = 1'b0, ACC_PAGED = 1'b1 } acc_kind_e;

    typedef struct packed {
        logic              valid;
        logic              wr;
        acc_kind_e         kind;
        logic [HI_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
        logic [DATA_W-1:0] wdata;
    } access_t;

    typedef struct packed {
        logic hit;
        logic ram_we;
        logic ext_rd;
        logic ext_wr;
        logic bus_wd;
        logic bus_take;
    } route_t;

    // one-way clear of the off bit, free write of the show bit
    function automatic logic [1:0] map_update(input logic [1:0] cur,
                                              input logic [1:0] wv);
        logic [1:0] nx;
        nx[MAP_SHOW_BIT] = wv[MAP_SHOW_BIT];
        nx[MAP_OFF_BIT]  = cur[MAP_OFF_BIT] & wv[MAP_OFF_BIT];
        return nx;
    endfunction

    function automatic logic [HI_W-1:0] eff_high(input access_t a,
                                                 input logic [HI_W-1:0] page);
        return (a.kind == ACC_PAGED) ? page : a.hi;
    endfunction

endpackage

// File: rtl/xram_cfg_regs.sv
module xram_cfg_regs
    import xram_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            win_we,
    input  logic [HI_W-1:0] win_wdata,
    input  logic            map_we,
    input  logic [1:0]      map_wdata,
    input  logic            page_we,
    input  logic [HI_W-1:0] page_wdata,
    input  logic            p2_we,
    input  logic [HI_W-1:0] p2_wdata,
    output logic [HI_W-1:0] win_q,
    output logic [1:0]      map_q,
    output logic [HI_W-1:0] page_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= WIN_RESET;
        end else if (win_we) begin
            win_q <= win_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= MAP_RESET;
        end else if (map_we) begin
            map_q <= map_update(map_q, map_wdata);
        end
    end

    // own strobe takes priority over the port-2 shadow copy
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= PAGE_RESET;
        end else if (page_we) begin
            page_q <= page_wdata;
        end else if (p2_we) begin
            page_q <= p2_wdata;
        end
    end

endmodule

// File: rtl/xram_route.sv
module xram_route
    import xram_pkg::*;
(
    input  access_t         acc,
    input  logic [HI_W-1:0] win,
    input  logic [HI_W-1:0] page,
    input  logic [1:0]      map,
    output route_t          rt
);

    logic enabled;
    logic match;

    always_comb begin
        enabled = ~map[MAP_OFF_BIT];
        match   = (eff_high(acc, page) == win);

        rt          = '0;
        rt.hit      = acc.valid & enabled & match;
        rt.ram_we   = rt.hit & acc.wr;
        rt.bus_wd   = acc.valid & acc.wr;
        rt.bus_take = acc.valid & ~acc.wr & ~rt.hit;
        if (acc.valid) begin
            if (!rt.hit || map[MAP_SHOW_BIT]) begin
                rt.ext_rd = ~acc.wr;
                rt.ext_wr = acc.wr;
            end
        end
    end

endmodule

// File: rtl/xram_array.sv
module xram_array
    import xram_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [LO_W-1:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    // storage deliberately carries no reset
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/xram_decoder.sv
module xram_decoder
    import xram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic              acc_paged,
    input  logic [HI_W-1:0]   acc_hi,
    input  logic [LO_W-1:0]   acc_lo,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              win_we,
    input  logic [HI_W-1:0]   win_wdata,
    input  logic              map_we,
    input  logic [1:0]        map_wdata,
    input  logic              page_we,
    input  logic [HI_W-1:0]   page_wdata,
    input  logic              p2_we,
    input  logic [HI_W-1:0]   p2_wdata,
    output logic [HI_W-1:0]   win_q,
    output logic [1:0]        map_q,
    output logic [HI_W-1:0]   page_q,
    output logic              xram_sel,
    output logic              xram_we,
    output logic              ext_rd_en,
    output logic              ext_wr_en,
    output logic              bus_wdata_en,
    output logic              bus_rdata_take,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rdata
);

    access_t acc;
    route_t  rt;

    always_comb begin
        acc.valid = acc_valid;
        acc.wr    = acc_wr;
        acc.kind  = acc_paged ? ACC_PAGED : ACC_POINTER;
        acc.hi    = acc_hi;
        acc.lo    = acc_lo;
        acc.wdata = acc_wdata;
    end

    xram_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .win_we     (win_we),
        .win_wdata  (win_wdata),
        .map_we     (map_we),
        .map_wdata  (map_wdata),
        .page_we    (page_we),
        .page_wdata (page_wdata),
        .p2_we      (p2_we),
        .p2_wdata   (p2_wdata),
        .win_q      (win_q),
        .map_q      (map_q),
        .page_q     (page_q)
    );

    xram_route u_route (
        .acc  (acc),
        .win  (win_q),
        .page (page_q),
        .map  (map_q),
        .rt   (rt)
    );

    xram_array u_array (
        .clk   (clk),
        .we    (rt.ram_we),
        .re    (rt.hit & ~acc.wr),
        .addr  (acc.lo),
        .wdata (acc.wdata),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hit <= 1'b0;
        end else begin
            rd_hit <= rt.hit & ~acc.wr;
        end
    end

    assign xram_sel       = rt.hit;
    assign xram_we        = rt.ram_we;
    assign ext_rd_en      = rt.ext_rd;
    assign ext_wr_en      = rt.ext_wr;
    assign bus_wdata_en   = rt.bus_wd;
    assign bus_rdata_take = rt.bus_take;

endmodule

// File: rtl/xram_decoder_chk.sv
module xram_decoder_chk
    import xram_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_wr,
    input logic              acc_paged,
    input logic [HI_W-1:0]   acc_hi,
    input logic [LO_W-1:0]   acc_lo,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              win_we,
    input logic [HI_W-1:0]   win_wdata,
    input logic              map_we,
    input logic [1:0]        map_wdata,
    input logic              page_we,
    input logic [HI_W-1:0]   page_wdata,
    input logic              p2_we,
    input logic [HI_W-1:0]   p2_wdata,
    input logic [HI_W-1:0]   win_q,
    input logic [1:0]        map_q,
    input logic [HI_W-1:0]   page_q,
    input logic              xram_sel,
    input logic              xram_we,
    input logic              ext_rd_en,
    input logic              ext_wr_en,
    input logic              bus_wdata_en,
    input logic              bus_rdata_take,
    input logic              rd_hit,
    input logic [DATA_W-1:0] rdata
);

    // R2
    map_off_chk: assert property (@(posedge clk) disable iff (rst)
        map_q[0] |-> !xram_sel);

    // R3
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !$rose(map_q[0]));

    // R4
    win_match_chk: assert property (@(posedge clk) disable iff (rst)
        (xram_sel && !acc_paged) |-> (acc_hi == win_q));

    // R5
    page_match_chk: assert property (@(posedge clk) disable iff (rst)
        (xram_sel && acc_paged) |-> (page_q == win_q));

    // R6
    ext_hide_chk: assert property (@(posedge clk) disable iff (rst)
        (xram_sel && !map_q[1]) |-> (!ext_rd_en && !ext_wr_en));

    // R7
    shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (p2_we && !page_we) |=> (page_q == $past(p2_wdata)));

    // R9
    bus_take_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_take |-> (!xram_sel && acc_valid && !acc_wr));

    // R10
    rd_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_wr && xram_sel) |=> rd_hit);

endmodule

bind xram_decoder xram_decoder_chk u_chk (.*);

// File: tb/xram_decoder_test.sv
module xram_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 0, acc_wr = 0, acc_paged = 0;
    logic [7:0] acc_hi = 0, acc_lo = 0, acc_wdata = 0;
    logic       win_we = 0, map_we = 0, page_we = 0, p2_we = 0;
    logic [7:0] win_wdata = 0, page_wdata = 0, p2_wdata = 0;
    logic [1:0] map_wdata = 0;
    logic [7:0] win_q, page_q, rdata;
    logic [1:0] map_q;
    logic       xram_sel, xram_we, ext_rd_en, ext_wr_en;
    logic       bus_wdata_en, bus_rdata_take, rd_hit;

    always #5 clk = ~clk;

    xram_decoder uut (.*);

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [7:0] m_win, m_page;
    logic [1:0] m_map;
    logic [7:0] m_mem [256];
    bit         m_ok  [256];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        m_win = 8'hF8; m_map = 2'b01; m_page = 8'h00;
    endtask

    task automatic wr_win(input logic [7:0] v);
        @(negedge clk); win_we = 1; win_wdata = v;
        @(negedge clk); win_we = 0; m_win = v;
    endtask

    task automatic wr_map(input logic [1:0] v);
        @(negedge clk); map_we = 1; map_wdata = v;
        @(negedge clk); map_we = 0;
        m_map = {v[1], m_map[0] & v[0]};
    endtask

    task automatic wr_page(input logic [7:0] v);
        @(negedge clk); page_we = 1; page_wdata = v;
        @(negedge clk); page_we = 0; m_page = v;
    endtask

    task automatic wr_p2(input logic [7:0] v);
        @(negedge clk); p2_we = 1; p2_wdata = v;
        @(negedge clk); p2_we = 0; m_page = v;
    endtask

    task automatic access(input logic paged, input logic wr, input logic [7:0] hi,
                          input logic [7:0] lo, input logic [7:0] d, input string req);
        logic hit, show;
        @(negedge clk);
        acc_valid = 1; acc_paged = paged; acc_wr = wr;
        acc_hi = hi; acc_lo = lo; acc_wdata = d;
        #1;
        hit  = !m_map[0] && ((paged ? m_page : hi) == m_win);
        show = !hit || m_map[1];
        chk(req, "xram_sel", xram_sel, hit);
        chk("R11", "xram_we", xram_we, hit & wr);
        chk(req, "ext_rd_en", ext_rd_en, !wr & show);
        chk(req, "ext_wr_en", ext_wr_en, wr & show);
        chk("R9", "bus_wdata_en", bus_wdata_en, wr);
        chk("R9", "bus_rdata_take", bus_rdata_take, !wr & !hit);
        @(negedge clk);
        acc_valid = 0; acc_wr = 0;
        chk("R10", "rd_hit", rd_hit, hit & !wr);
        if (hit && !wr && m_ok[lo]) chk(req, "rdata", rdata, m_mem[lo]);
        if (hit && wr) begin m_mem[lo] = d; m_ok[lo] = 1; end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_ok[i] = 0;
        do_reset();
        // R1 reset values
        chk("R1", "win_q", win_q, 8'hF8);
        chk("R1", "map_q", map_q, 2'b01);
        chk("R1", "page_q", page_q, 8'h00);
        chk("R1", "rd_hit", rd_hit, 0);

        // R2 disabled after reset, every high byte goes external
        for (int h = 0; h < 256; h++) access(0, h[0], h[7:0], h[7:0], 8'h11, "R2");
        wr_page(8'hF8);
        access(1, 0, 8'h00, 8'h05, 0, "R2");

        // R3 one-way clear
        wr_map(2'b00); chk("R3", "map_q", map_q, 2'b00);
        wr_map(2'b01); chk("R3", "map_q", map_q, 2'b00);
        wr_map(2'b11); chk("R3", "map_q", map_q, 2'b10);
        wr_map(2'b00); chk("R3", "map_q", map_q, 2'b00);

        // R4 pointer decode sweep against a moved window
        wr_win(8'h3C); chk("R4", "win_q", win_q, 8'h3C);
        for (int h = 0; h < 256; h++) access(0, h[0], h[7:0], h[7:0], h[7:0] ^ 8'h5A, "R4");

        // R11 fill the array, then R10 read it all back
        for (int l = 0; l < 256; l++) access(0, 1, 8'h3C, l[7:0], l[7:0] ^ 8'hA5, "R11");
        for (int l = 0; l < 256; l++) access(0, 0, 8'h3C, l[7:0], 8'h00, "R10");

        // R7 shadow copy and strobe priority
        wr_p2(8'h3C); chk("R7", "page_q", page_q, 8'h3C);
        @(negedge clk); page_we = 1; page_wdata = 8'h11; p2_we = 1; p2_wdata = 8'h22;
        @(negedge clk); page_we = 0; p2_we = 0; m_page = 8'h11;
        chk("R7", "page_q", page_q, 8'h11);

        // R5 paged decode sweep; pointer byte held at window value
        for (int p = 0; p < 256; p++) begin
            wr_page(p[7:0]);
            access(1, 0, 8'h3C, p[7:0], 8'h00, "R5");
        end
        wr_page(8'h3C);
        access(1, 1, 8'h00, 8'h07, 8'hC3, "R5");
        access(1, 0, 8'h00, 8'h07, 8'h00, "R5");

        // R6 strobes shown during internal accesses when bit 1 is set
        wr_map(2'b10);
        for (int l = 0; l < 8; l++) begin
            access(0, 1, 8'h3C, l[7:0], l[7:0] + 8'h40, "R6");
            access(0, 0, 8'h3C, l[7:0], 8'h00, "R6");
            access(0, 0, 8'h3D, l[7:0], 8'h00, "R6");
        end
        wr_map(2'b00);
        access(0, 0, 8'h3C, 8'h02, 8'h00, "R6");

        // R8 contents survive reset
        do_reset();
        chk("R1", "map_q", map_q, 2'b01);
        chk("R1", "win_q", win_q, 8'hF8);
        access(0, 0, 8'hF8, 8'h01, 8'h00, "R2");
        wr_map(2'b00); wr_win(8'h3C);
        for (int l = 0; l < 256; l++) access(0, 0, 8'h3C, l[7:0], 8'h00, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule